// File: doc/BRIEF.md
# Prescaled Timebase Counter with Flag

This block produces a fixed system time reference from the main clock. A divide-by-32 prescaler feeds an 8-bit counter that counts modulo 250. Each wrap of that counter marks one timebase period, which is 8000 clock cycles, or 1 ms at 8 MHz. A control input can select a doubled period. At the end of each period the block raises a one-cycle tick for neighbouring logic. It also sets a sticky flag, which can request an interrupt.

The counter value is internal and has no read or write path. Software learns about periods only through the flag. The flag is cleared as a side effect of a status-register read, which arrives here as a one-cycle strobe from the bus decoder. A halt input stands for the stopped oscillator and freezes all counting. The block carries no data stream, so every pin is a plain control or status level or pulse, with no valid/ready handshake.

Top module: `tbase_top`

## Requirements
- R1: Out of reset, flag_o, irq_o and tick_o are 0, and the prescaler and counter start from zero. The first tick therefore follows exactly 8000 non-halted cycles after reset release.
- R2: With dbl_i=0, tick_o pulses high for exactly one cycle after every 8000 non-halted cycles. This is 32 clocks per count times 250 counts, with the count wrapping from 249 to 0.
- R3: With dbl_i=1, tick_o and the flag fire only on every second wrap, every 16000 non-halted cycles. The first wrap after reset produces neither.
- R4: flag_o goes to 1 in the same cycle that tick_o is high. It then stays at 1 until a status read.
- R5: A one-cycle stat_rd_i pulse, with no tick in that cycle, clears flag_o from the next cycle on.
- R6: If stat_rd_i coincides with the cycle that produces a tick, flag_o stays at 1.
- R7: irq_o is 1 exactly when flag_o is 1 and irq_en_i is 1. With irq_en_i=0, a set flag raises no request.
- R8: While halt_i is 1, neither the prescaler nor the counter advances. The next tick is delayed by exactly the number of halted cycles.
- R9: Status reads have no effect on the count, so the tick cadence is unchanged by reads made at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (oscillator) |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_i | input | 1 | Oscillator stopped; freezes counting |
| stat_rd_i | input | 1 | One-cycle strobe: status register read |
| dbl_i | input | 1 | 1 selects the doubled period |
| irq_en_i | input | 1 | Interrupt enable |
| flag_o | output | 1 | Sticky period-elapsed flag |
| irq_o | output | 1 | Interrupt request |
| tick_o | output | 1 | One-cycle pulse at each period end |

## Verification
The bench predicts every tick from its own count of non-halted cycles and compares it with the observed tick. This catches a counter wrapping at 255 instead of 249, a prescaler with an off-by-one, or a halt that fails to freeze counting, because each of these moves the tick. In doubled mode it watches the first wrap, where a design that ignores the toggle would fire early. It places a status read in the exact cycle of a set, where a design that gives the clear priority would lose the event. It also checks that a masked interrupt stays low while the flag is up, and that reads scattered through a period leave the cadence untouched.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  parameter int unsigned PRE_DIV  = 32;
  parameter int unsigned BASE_MOD = 250;
endpackage

// File: rtl/tbase_prescale.sv
module tbase_prescale #(
  parameter int unsigned DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_i,
  output logic en_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign en_o = !halt_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!halt_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  a_r8_pre_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> $stable(cnt_q));
  a_r2_en_single: assert property (@(posedge clk) disable iff (!rst_n)
    en_o |=> !en_o);
endmodule

// File: rtl/tbase_wrap.sv
module tbase_wrap #(
  parameter int unsigned MOD = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic wrap_o
);
  localparam int unsigned W = $clog2(MOD);
  localparam logic [W-1:0] TOP = W'(MOD - 1);

  logic [W-1:0] cnt_q;

  assign wrap_o = en_i && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (en_i) cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
  end

  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);
  a_r8_hold_no_en: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/tbase_period.sv
module tbase_period (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_i,
  input  logic dbl_i,
  output logic tick_o
);
  logic half_q;

  assign tick_o = wrap_i && (!dbl_i || half_q);

  always_ff @(posedge clk) begin
    if (!rst_n)      half_q <= 1'b0;
    else if (wrap_i) half_q <= dbl_i ? !half_q : 1'b0;
  end

  a_r3_skip_first: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && dbl_i && !half_q) |-> !tick_o);
endmodule

// File: rtl/tbase_flag.sv
module tbase_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic rd_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o,
  output logic tick_o
);
  logic flag_q, tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= tick_i;
      if (tick_i)    flag_q <= 1'b1;
      else if (rd_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign tick_o = tick_q;
  assign irq_o  = flag_q && irq_en_i;

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> flag_o);
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !tick_i) |=> !flag_o);
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !rd_i) |=> flag_o);
endmodule

// File: rtl/tbase_top.sv
module tbase_top
  import tbase_pkg::*;
#(
  parameter int unsigned DIV = PRE_DIV,
  parameter int unsigned MOD = BASE_MOD
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_i,
  input  logic stat_rd_i,
  input  logic dbl_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o,
  output logic tick_o
);
  logic en, wrap, tick;

  tbase_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .en_o(en));

  tbase_wrap #(.MOD(MOD)) u_wrap (
    .clk(clk), .rst_n(rst_n), .en_i(en), .wrap_o(wrap));

  tbase_period u_per (
    .clk(clk), .rst_n(rst_n), .wrap_i(wrap), .dbl_i(dbl_i), .tick_o(tick));

  tbase_flag u_flag (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .rd_i(stat_rd_i),
    .irq_en_i(irq_en_i), .flag_o(flag_o), .irq_o(irq_o), .tick_o(tick_o));

  a_r4_tick_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> flag_o);
  a_r7_irq_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |-> !irq_o);
endmodule

// File: tb/sim_tbase_top.sv
module sim_tbase_top;
  logic clk = 1'b0, rst_n = 1'b0, halt = 1'b0, rd = 1'b0, dbl = 1'b0, ie = 1'b0;
  logic flag, irq, tick;
  int act = 0, cyc = 0, nchk = 0, nfail = 0;
  int exp_q[$];
  string cur_tag = "R2";
  bit done = 0;

  always #4 clk = ~clk;

  tbase_top u0 (.clk(clk), .rst_n(rst_n), .halt_i(halt), .stat_rd_i(rd),
    .dbl_i(dbl), .irq_en_i(ie), .flag_o(flag), .irq_o(irq), .tick_o(tick));

  always @(posedge clk) begin
    if (!rst_n) act <= 0;
    else if (!halt) act <= act + 1;
  end

  task automatic check(input bit ok, input string tag, input int a, input int e);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
    end
  endtask

  // monitor: each tick pops the expected period end
  always @(negedge clk) begin
    if (rst_n && tick) begin
      if (exp_q.size() == 0) check(0, cur_tag, act, -1);
      else begin
        automatic int e = exp_q.pop_front();
        check(act == e, cur_tag, act, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      check(0, "watchdog", cyc, 200000);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic do_reset();
    rst_n = 0; rd = 0; halt = 0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_act(input int n);
    while (act < n) @(negedge clk);
  endtask

  task automatic read_pulse();
    rd = 1; @(negedge clk); rd = 0;
  endtask

  initial begin
    // Phase A: normal period, irq enabled
    dbl = 0; ie = 1; cur_tag = "R2";
    do_reset();
    check(flag == 0 && irq == 0 && tick == 0, "R1", {flag, irq, tick}, 0);
    exp_q.push_back(8000); exp_q.push_back(16000);
    wait_act(7999);
    check(flag == 0, "R1", flag, 0);
    wait_act(8000);
    check(flag == 1, "R4", flag, 1);
    check(irq == 1, "R7", irq, 1);
    repeat (5) @(negedge clk);
    check(flag == 1, "R4", flag, 1);
    check(tick == 0, "R2", tick, 0);
    read_pulse();
    check(flag == 0 && irq == 0, "R5", flag, 0);
    wait_act(10000); read_pulse();
    wait_act(12345); read_pulse();
    check(flag == 0, "R9", flag, 0);
    wait_act(16000);
    check(flag == 1, "R9", flag, 1);
    wait_act(16100);
    check(exp_q.size() == 0, "R2", exp_q.size(), 0);

    // Phase B: doubled period, irq masked
    dbl = 1; ie = 0; cur_tag = "R3";
    do_reset();
    exp_q.push_back(16000); exp_q.push_back(32000);
    wait_act(8002);
    check(flag == 0, "R3", flag, 0);
    wait_act(16000);
    check(flag == 1, "R3", flag, 1);
    check(irq == 0, "R7", irq, 0);
    read_pulse();
    wait_act(32010);
    check(exp_q.size() == 0, "R3", exp_q.size(), 0);

    // Phase C: halt freezes counting
    dbl = 0; ie = 1; cur_tag = "R8";
    do_reset();
    exp_q.push_back(8000);
    wait_act(3000);
    halt = 1;
    repeat (1000) @(negedge clk);
    check(act == 3000 && flag == 0, "R8", act, 3000);
    halt = 0;
    wait_act(8000);
    check(flag == 1, "R8", flag, 1);
    wait_act(8010);
    check(exp_q.size() == 0, "R8", exp_q.size(), 0);

    // Phase D: read coincides with set
    cur_tag = "R6";
    do_reset();
    exp_q.push_back(8000);
    wait_act(7999);
    read_pulse();
    check(flag == 1, "R6", flag, 1);
    read_pulse();
    check(flag == 0, "R5", flag, 0);
    check(exp_q.size() == 0, "R6", exp_q.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule